// File: doc/BRIEF.md
# Strobe-Handshaked FIFO with Occupancy Flags

This block is a 64-word by 9-bit first-in first-out buffer with pulse handshakes on both sides. The writer raises a shift-in strobe while the input-ready output is high. The rising edge captures the data word, and input-ready stays low until the strobe falls again. The reader watches an output-ready indication and the head word on the data outputs. It pulses a shift-out strobe to take the word off, and the next word, or zero, then appears on the outputs.

Words sit in a dual-port array addressed by a write pointer and a read pointer, so an access moves a pointer and never the data. Both strobes are synchronous inputs sampled on the single clock, and the block finds their edges itself. Two registered status flags report the stored count. One is a combined near-empty/near-full flag. The other marks the half-full point. Both flags change only on a falling edge of either strobe.

Top module: `fifo64_shift`

## Requirements
- R1: After a synchronous reset, out_ready is 0, in_ready is 1, data_out is 0, edge_flag is 1 and half_flag is 0.
- R2: A rising edge of shift_in while in_ready is 1 stores data_in, and in_ready reads 0 in the cycle after that edge.
- R3: When shift_in falls, in_ready returns to 1 unless 64 words are stored. When a read frees a slot in a full buffer while shift_in is low, in_ready returns to 1 after the shift_out rising edge.
- R4: A shift_in rising edge while in_ready is 0 changes nothing: no word is stored and no stored word is overwritten.
- R5: With no words stored, out_ready is 0, data_out is 0, and shift_out pulses have no effect.
- R6: Once a word is stored, out_ready is 1 and data_out shows the oldest stored word. Words leave in the order they were written.
- R7: A shift_out rising edge while out_ready is 1 removes the head word. data_out then shows the next word, or 0 if none remain. out_ready is 0 in the cycle after that edge and returns to 1 on the shift_out fall only if words remain.
- R8: edge_flag is 1 when the stored count is at most 8 or at least 56, and 0 otherwise.
- R9: half_flag is 1 when the stored count is at least 32, and 0 otherwise.
- R10: Both flags take their new values only on a falling edge of shift_in or shift_out. In the cycle after a rising edge they still hold their earlier values.
- R11: A write and a read accepted at the same clock edge leave the stored count unchanged. If the buffer held exactly one word, the newly written word appears on data_out at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the empty state |
| shift_in | input | 1 | Write strobe; rising edge captures data_in |
| data_in | input | 9 | Word to store |
| in_ready | output | 1 | High when a write will be accepted |
| shift_out | input | 1 | Read strobe; rising edge removes the head word |
| out_ready | output | 1 | High when a head word is available |
| data_out | output | 9 | Head word, zero when empty |
| edge_flag | output | 1 | Near-empty or near-full flag |
| half_flag | output | 1 | Half-full flag |

## Verification
The bench fills the buffer through the flag thresholds at 8/9, 32 and 55/56 and checks that neither flag moves mid-pulse. A design that updated the flags on rising edges would show the new flag one cycle early. At full, a rejected write must leave the head word and the count intact; an overwrite would surface as a wrong word during the drain. A read from a full buffer must raise in_ready without any shift_in activity. A simultaneous write and read on a one-word buffer must show the new word at once; a design without the write bypass would present a stale array word.

// File: rtl/shfifo_pkg.sv
package shfifo_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } strobe_ev_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
  import shfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strb,
  output strobe_ev_t ev
);
  logic strb_q;

  always_ff @(posedge clk) begin
    if (rst) strb_q <= 1'b0;
    else     strb_q <= strb;
  end

  always_comb begin
    ev.rise = strb & ~strb_q;
    ev.fall = ~strb & strb_q;
  end
endmodule

// File: rtl/shfifo_mem.sv
module shfifo_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic             clr,
  output logic [WIDTH-1:0] rd_q
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                      rd_q <= '0;
    else if (wr_en && wr_addr == rd_addr) rd_q <= wr_data;
    else                                  rd_q <= cells[rd_addr];
  end
endmodule

// File: rtl/shfifo_flags.sv
module shfifo_flags #(
  parameter int DEPTH     = 64,
  parameter int LOW_MARK  = 8,
  parameter int HIGH_MARK = 56,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [CW-1:0] count,
  output logic          edge_flag,
  output logic          half_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      edge_flag <= 1'b1;
      half_flag <= 1'b0;
    end else if (upd) begin
      edge_flag <= (count <= CW'(LOW_MARK)) || (count >= CW'(HIGH_MARK));
      half_flag <= (count >= CW'(DEPTH / 2));
    end
  end

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(edge_flag) && $stable(half_flag));
endmodule

// File: rtl/fifo64_shift.sv
module fifo64_shift
  import shfifo_pkg::*;
#(
  parameter int WIDTH     = 9,
  parameter int DEPTH     = 64,
  parameter int LOW_MARK  = 8,
  parameter int HIGH_MARK = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] data_in,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  output logic [WIDTH-1:0] data_out,
  output logic             edge_flag,
  output logic             half_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [1:0]  strobes;
  strobe_ev_t  ev [2];

  assign strobes = {shift_out, shift_in};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    strobe_edge u_edge (
      .clk (clk),
      .rst (rst),
      .strb(strobes[g]),
      .ev  (ev[g])
    );
  end

  logic [AW-1:0] wptr, rptr, rptr_n;
  logic [CW-1:0] count, count_n;
  logic          wr_busy, rd_busy, wr_busy_n, rd_busy_n;
  logic          wr_acc, rd_acc;

  assign wr_acc = ev[0].rise & in_ready;
  assign rd_acc = ev[1].rise & out_ready;

  always_comb begin
    count_n = count;
    if (wr_acc && !rd_acc)      count_n = count + 1'b1;
    else if (rd_acc && !wr_acc) count_n = count - 1'b1;
    rptr_n    = rd_acc ? rptr + 1'b1 : rptr;
    wr_busy_n = wr_acc ? 1'b1 : (ev[0].fall ? 1'b0 : wr_busy);
    rd_busy_n = rd_acc ? 1'b1 : (ev[1].fall ? 1'b0 : rd_busy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      wr_busy   <= 1'b0;
      rd_busy   <= 1'b0;
      in_ready  <= 1'b1;
      out_ready <= 1'b0;
    end else begin
      if (wr_acc) wptr <= wptr + 1'b1;
      rptr      <= rptr_n;
      count     <= count_n;
      wr_busy   <= wr_busy_n;
      rd_busy   <= rd_busy_n;
      in_ready  <= !wr_busy_n && (count_n != CW'(DEPTH));
      out_ready <= !rd_busy_n && (count_n != '0);
    end
  end

  shfifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_acc),
    .wr_addr(wptr),
    .wr_data(data_in),
    .rd_addr(rptr_n),
    .clr    (count_n == '0),
    .rd_q   (data_out)
  );

  shfifo_flags #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .upd      (ev[0].fall | ev[1].fall),
    .count    (count),
    .edge_flag(edge_flag),
    .half_flag(half_flag)
  );

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R4
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    ev[0].rise && !in_ready && !rd_acc |=> count == $past(count));
  // R2
  write_ack_chk: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> !in_ready);
  // R5
  empty_out_chk: assert property (@(posedge clk) disable iff (rst)
    count == '0 |-> !out_ready && data_out == '0);
  // R7
  read_ack_chk: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> !out_ready);
  // R11
  both_count_chk: assert property (@(posedge clk) disable iff (rst)
    wr_acc && rd_acc |=> count == $past(count));
endmodule

// File: tb/fifo64_shift_test.sv
module fifo64_shift_test;
  localparam int W = 9;
  localparam int D = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shift_in = 1'b0;
  logic         shift_out = 1'b0;
  logic [W-1:0] data_in = '0;
  logic         in_ready, out_ready, edge_flag, half_flag;
  logic [W-1:0] data_out;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mdl [D];
  int head = 0;
  int cnt = 0;

  always #5 clk = ~clk;

  fifo64_shift uut (
    .clk(clk), .rst(rst), .shift_in(shift_in), .data_in(data_in),
    .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
    .data_out(data_out), .edge_flag(edge_flag), .half_flag(half_flag)
  );

  // op[21:20]: 1 write, 2 read, 3 both; data[19:11]; exp data_out[10:2]; edge[1]; half[0]
  localparam logic [21:0] VEC [11] = '{
    {2'd1, 9'h011, 9'h011, 1'b1, 1'b0},
    {2'd1, 9'h122, 9'h011, 1'b1, 1'b0},
    {2'd1, 9'h1FF, 9'h011, 1'b1, 1'b0},
    {2'd2, 9'h000, 9'h122, 1'b1, 1'b0},
    {2'd3, 9'h033, 9'h1FF, 1'b1, 1'b0},
    {2'd2, 9'h000, 9'h033, 1'b1, 1'b0},
    {2'd2, 9'h000, 9'h000, 1'b1, 1'b0},
    {2'd2, 9'h000, 9'h000, 1'b1, 1'b0},
    {2'd1, 9'h155, 9'h155, 1'b1, 1'b0},
    {2'd3, 9'h0AA, 9'h0AA, 1'b1, 1'b0},
    {2'd2, 9'h000, 9'h000, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, "data_out", data_out, cnt > 0 ? mdl[head] : '0);
    chk(req, "out_ready", W'(out_ready), W'(cnt > 0));
    chk(req, "in_ready", W'(in_ready), W'(cnt < D));
    chk("R8", "edge_flag", W'(edge_flag), W'(cnt <= 8 || cnt >= 56));
    chk("R9", "half_flag", W'(half_flag), W'(cnt >= 32));
  endtask

  // one pulse on the selected strobes; model updated at the rising edge
  task automatic pulse(input logic do_w, input logic do_r, input logic [W-1:0] d);
    logic pe, ph, wa, ra;
    pe = edge_flag; ph = half_flag;
    wa = do_w && in_ready;
    ra = do_r && out_ready;
    @(negedge clk);
    data_in = d; shift_in = do_w; shift_out = do_r;
    @(posedge clk);
    @(negedge clk);
    if (ra) begin head = (head + 1) % D; cnt--; end
    if (wa) begin mdl[(head + cnt) % D] = d; cnt++; end
    chk("R10", "edge_flag mid", W'(edge_flag), W'(pe));
    chk("R10", "half_flag mid", W'(half_flag), W'(ph));
    if (wa) chk("R2", "in_ready mid", W'(in_ready), '0);
    if (ra) chk("R7", "out_ready mid", W'(out_ready), '0);
    if (ra && !do_w) chk("R3", "in_ready after read", W'(in_ready), W'(cnt < D));
    if (ra || wa) chk("R7", "data_out mid", data_out, cnt > 0 ? mdl[head] : '0);
    shift_in = 1'b0; shift_out = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "out_ready", W'(out_ready), '0);
    chk("R1", "in_ready", W'(in_ready), 1);
    chk("R1", "data_out", data_out, '0);
    chk("R1", "edge_flag", W'(edge_flag), 1);
    chk("R1", "half_flag", W'(half_flag), '0);

    // table walk: R5 R6 R7 R11
    for (int i = 0; i < 11; i++) begin
      pulse(VEC[i][20], VEC[i][21], VEC[i][19:11]);
      chk("R11", "table data_out", data_out, VEC[i][10:2]);
      chk("R8", "table edge_flag", W'(edge_flag), W'(VEC[i][1]));
      chk("R9", "table half_flag", W'(half_flag), W'(VEC[i][0]));
    end
    chk("R5", "out_ready empty", W'(out_ready), '0);

    // fill to full, R6 R8 R9 R10
    for (int i = 0; i < D; i++) begin
      pulse(1'b1, 1'b0, W'(i * 37 + 5));
      chk_state("R6");
    end
    chk("R3", "in_ready full", W'(in_ready), '0);
    // R4 rejected write
    pulse(1'b1, 1'b0, 9'h1AB);
    chk_state("R4");
    // R3 read from full raises in_ready
    pulse(1'b0, 1'b1, '0);
    chk_state("R3");
    pulse(1'b1, 1'b0, 9'h0F0);
    chk_state("R3");
    // drain, order check R6 R7
    while (cnt > 0) begin
      pulse(1'b0, 1'b1, '0);
      chk_state("R7");
    end
    // R5 ignored read on empty
    pulse(1'b0, 1'b1, '0);
    chk_state("R5");

    // R1 reset mid-stream
    pulse(1'b1, 1'b0, 9'h077);
    pulse(1'b1, 1'b0, 9'h078);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    cnt = 0; head = 0;
    chk_state("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule